// File: doc/BRIEF.md
# Subcarrier Phase Accumulator with Field-Sequenced Reload

This block generates the colour subcarrier phase for a composite video encoder. A 32-bit accumulator adds a programmable frequency word on every pixel clock. Its upper bits would feed a sine lookup further down the chain.

Small clock errors would make the subcarrier drift against horizontal sync over time. To stop this, the block keeps a field counter and can force the accumulator back to zero at a field start. A two-bit mode input picks one of three behaviours:

- the reload happens automatically once per colour sequence;
- the reload never happens, so an unstable source is tracked;
- the reload happens only when requested, at the first field start after the request.

A one-cycle strobe marks every reload.

Top module: `subcarrier_dds`

## Requirements
- R1: While `rst_n` is low, `phase` is 0, `field_num` is 0, `reload_pulse` is 0 and the internal frequency word is 32'h21F07C16. The first clock after release therefore gives `phase` = 32'h21F07C16.
- R2: On every clock edge without a reload, `phase` becomes the old `phase` plus the frequency word, modulo 2^32.
- R3: When `freq_wr` is high at an edge, the frequency word takes `freq_in`. The add at that same edge still uses the old word, and the new word is used from the next edge on.
- R4: `field_num` changes only at edges with `field_start` high. It counts up and wraps to 0 after 3 when `pal_sel`=0 (4-field sequence), or after 7 when `pal_sel`=1 (8-field sequence). A value above the limit also wraps to 0.
- R5: With `mode[0]`=0 (automatic), a `field_start` edge where `field_num` wraps to 0 also sets `phase` to 0.
- R6: With `mode`=2'b11 (tracking), `phase` is never reloaded, while `field_num` keeps counting.
- R7: With `mode`=2'b01 (requested), a `phase_req` pulse is held pending. At the next later `field_start` edge, `phase` and `field_num` become 0 and the pending request clears. A `field_start` in the same cycle as the request does not service it.
- R8: With `mode`=2'b01 and no request, `phase` is never reloaded.
- R9: `reload_pulse` is high for exactly the one cycle after an edge that reloaded `phase`, and low otherwise.
- R10: A `phase_req` given while `mode` is not 2'b01 is ignored. A pending request is dropped when `mode` leaves 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| field_start | input | 1 | One-cycle strobe at the start of each field |
| pal_sel | input | 1 | 0 selects a 4-field sequence, 1 selects an 8-field sequence |
| mode | input | 2 | Reload policy: bit0=0 automatic, 2'b01 on request, 2'b11 never |
| phase_req | input | 1 | Request a phase reload at the next field start |
| freq_wr | input | 1 | Write strobe for the frequency word |
| freq_in | input | 32 | New frequency word |
| phase | output | 32 | Accumulator phase |
| field_num | output | 3 | Current field within the sequence |
| reload_pulse | output | 1 | One-cycle strobe after a phase reload |

## Verification
A wrong frequency word or a wrong add shows on `phase` at the very next clock, and the error grows every cycle after that. A field counter that is off by one, or that uses the wrong modulus, shows first as a misplaced `reload_pulse` and a zero `phase` in automatic mode. This appears at most eight field starts later. A stale or lost pending request stays hidden until the next field start, where it shows as an extra or a missing reload. The bench therefore issues requests next to field starts and next to mode changes.

// File: rtl/subcarrier_dds.sv
module subcarrier_dds #(
  parameter int PHASE_W = 32,
  parameter int FIELD_W = 3,
  parameter logic [PHASE_W-1:0] FREQ_RST = 32'h21F07C16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               field_start,
  input  logic               pal_sel,
  input  logic [1:0]         mode,
  input  logic               phase_req,
  input  logic               freq_wr,
  input  logic [PHASE_W-1:0] freq_in,
  output logic [PHASE_W-1:0] phase,
  output logic [FIELD_W-1:0] field_num,
  output logic               reload_pulse
);
  localparam logic [FIELD_W-1:0] LAST_NTSC = FIELD_W'(3);
  localparam logic [FIELD_W-1:0] LAST_PAL  = FIELD_W'(7);

  logic [PHASE_W-1:0] freq_q;
  logic               pend_q;
  logic [FIELD_W-1:0] last_fld;
  logic               wrap, auto_mode, req_mode, reload;

  assign last_fld  = pal_sel ? LAST_PAL : LAST_NTSC;
  assign wrap      = field_num >= last_fld;
  assign auto_mode = ~mode[0];
  assign req_mode  = (mode == 2'b01);
  assign reload    = field_start & ((auto_mode & wrap) | (req_mode & pend_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_q       <= FREQ_RST;
      phase        <= '0;
      field_num    <= '0;
      pend_q       <= 1'b0;
      reload_pulse <= 1'b0;
    end else begin
      if (freq_wr) freq_q <= freq_in;
      phase        <= reload ? '0 : phase + freq_q;
      reload_pulse <= reload;
      pend_q       <= req_mode & (phase_req | (pend_q & ~field_start));
      if (field_start)
        field_num <= (reload | wrap) ? '0 : field_num + 1'b1;
    end
  end

  assert_pulse_phase_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reload_pulse |-> (phase == '0));
  assert_pulse_after_field_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && reload_pulse |-> $past(field_start));
  assert_track_no_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && reload_pulse |-> ($past(mode) != 2'b11));
  assert_accumulate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !reload_pulse |-> (phase == $past(phase) + $past(freq_q)));
  assert_field_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(field_start) |-> $stable(field_num));
  assert_ntsc_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    field_start && !pal_sel |=> (field_num < FIELD_W'(4)));
endmodule

// File: tb/subcarrier_dds_tb.sv
`timescale 1ns/1ps
module subcarrier_dds_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        field_start = 0, pal_sel = 0, phase_req = 0, freq_wr = 0;
  logic [1:0]  mode = 2'b00;
  logic [31:0] freq_in = '0;
  logic [31:0] phase;
  logic [2:0]  field_num;
  logic        reload_pulse;

  int errors = 0, checks = 0;
  logic [31:0] m_phase, m_freq;
  logic [2:0]  m_fld;
  logic        m_pend, m_pulse;
  int          pulses;

  always #2 clk = ~clk;

  subcarrier_dds dut_i (.clk, .rst_n, .field_start, .pal_sel, .mode, .phase_req,
                        .freq_wr, .freq_in, .phase, .field_num, .reload_pulse);

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [2:0] last_of(logic p);
    return p ? 3'd7 : 3'd3;
  endfunction

  task automatic model_reset();
    m_phase = 0; m_freq = 32'h21F07C16; m_fld = 0; m_pend = 0; m_pulse = 0;
  endtask

  task automatic model_step();
    logic wr_, rl;
    wr_ = (m_fld >= last_of(pal_sel));
    rl  = field_start && ((!mode[0] && wr_) || (mode == 2'b01 && m_pend));
    m_phase = rl ? 32'd0 : m_phase + m_freq;
    if (freq_wr) m_freq = freq_in;
    if (field_start) m_fld = (rl || wr_) ? 3'd0 : m_fld + 3'd1;
    m_pend  = (mode == 2'b01) && (phase_req || (m_pend && !field_start));
    m_pulse = rl;
  endtask

  task automatic step(logic fs, logic rq, logic wr, logic [31:0] wd);
    field_start = fs; phase_req = rq; freq_wr = wr; freq_in = wd;
    @(posedge clk);
    model_step();
    #1;
    check("R2 phase", phase, m_phase);
    check("R4 field_num", {29'd0, field_num}, {29'd0, m_fld});
    check("R9 reload_pulse", {31'd0, reload_pulse}, {31'd0, m_pulse});
    if (reload_pulse) pulses++;
    field_start = 0; phase_req = 0; freq_wr = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R1 phase", phase, 0);
    check("R1 field_num", {29'd0, field_num}, 0);
    check("R1 reload_pulse", {31'd0, reload_pulse}, 0);
    @(negedge clk); rst_n = 1;
    step(0, 0, 0, 0);
    check("R1 freq reset word", phase, 32'h21F07C16);
    idle(5);

    // R2 wrap and R3 write timing
    step(0, 0, 1, 32'hC000_0000);
    check("R3 old word on write edge", phase, 32'h21F07C16 * 7);
    step(0, 0, 0, 0);
    check("R3 new word next edge", phase, 32'h21F07C16 * 7 + 32'hC000_0000);
    idle(3);

    // R5 automatic, NTSC: wrap on 4th field start
    mode = 2'b00; pal_sel = 0;
    while (m_fld != 0) begin step(1, 0, 0, 0); idle(2); end
    idle(3);
    for (int f = 0; f < 4; f++) begin step(1, 0, 0, 0); if (f < 3) idle(2); end
    check("R5 auto reload phase", phase, 0);
    check("R5 auto reload pulse", {31'd0, reload_pulse}, 1);
    pulses = 0;
    pal_sel = 1;
    for (int f = 0; f < 8; f++) begin step(1, 0, 0, 0); idle(2); end
    check("R5 PAL one reload per 8 fields", pulses, 1);

    // R6 tracking
    mode = 2'b11; pulses = 0;
    for (int f = 0; f < 16; f++) begin step(1, f == 2, 0, 0); idle(1); end
    check("R6 tracking no reload", pulses, 0);

    // R8 requested mode without a request
    mode = 2'b01; pulses = 0;
    for (int f = 0; f < 10; f++) begin step(1, 0, 0, 0); idle(1); end
    check("R8 no request no reload", pulses, 0);

    // R7 request with coincident field start is served at the following one
    while (m_fld != 3'd4) begin step(1, 0, 0, 0); end
    step(1, 1, 0, 0);
    check("R7 not served same cycle", {31'd0, reload_pulse}, 0);
    check("R7 field advanced", {29'd0, field_num}, 5);
    idle(3);
    check("R7 still pending, no reload", {31'd0, reload_pulse}, 0);
    step(1, 0, 0, 0);
    check("R7 served at next field", {31'd0, reload_pulse}, 1);
    check("R7 field zero", {29'd0, field_num}, 0);
    check("R7 phase zero", phase, 0);
    pulses = 0;
    step(1, 0, 0, 0);
    check("R7 request cleared after service", pulses, 0);

    // R10 request outside requested mode, and pending dropped
    mode = 2'b10; pal_sel = 1;
    while (m_fld != 3'd2) step(1, 0, 0, 0);
    step(0, 1, 0, 0);
    mode = 2'b01; pulses = 0;
    step(1, 0, 0, 0);
    check("R10 request in auto mode ignored", pulses, 0);
    step(0, 1, 0, 0);
    mode = 2'b11; idle(1);
    mode = 2'b01; pulses = 0;
    step(1, 0, 0, 0);
    check("R10 pending dropped on mode change", pulses, 0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 99) == 0) mode = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 199) == 0) pal_sel = ~pal_sel;
      step($urandom_range(0, 7) == 0, $urandom_range(0, 15) == 0,
           $urandom_range(0, 31) == 0, $urandom);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule